// File: doc/BRIEF.md
# Debug Run-Control Register Front End

This block sits between an external debugger and a single processor core. The debugger sends one request at a time over a valid/ready channel. Each request carries a 32-bit address, 32-bit data and a 2-bit operation code. The block answers each request exactly once over a second valid/ready channel. The answer carries 32-bit data and a 2-bit status code.

Three registers are decoded: a control word, a status word and a hart-information word. The control word drives three outputs to the core: a halt request, a resume request and a non-debug system reset request. The status word reports the core's halted, running, have-reset and resume-acknowledge signals. It also reports a fixed version number.

Abstract commands, memory access and hart selection belong to other blocks. A request to any address outside the three decoded registers is answered as a failure.

Top module: `dbg_runctl`

## Requirements
- R1: After reset, `rspValid` is 0, `reqReady` is 1, and `haltReq`, `resumeReq` and `sysResetReq` are all 0.
- R2: A request accepted at a clock edge (`reqValid` and `reqReady` both high) produces `rspValid` high after that edge. While `rspValid` is high, `reqReady` is low. While `rspReady` is low, `rspData` and `rspStat` hold their values.
- R3: Operation codes are NOP=0, READ=1 and WRITE=2. Response status codes are SUCCESS=0, FAILED=1 and BUSY=2. A NOP is answered with SUCCESS and data 0. Operation code 3 is answered with FAILED and data 0. No response carries status 3.
- R4: The control register is at address 0x10. Its bits are: bit 31 = halt request, bit 30 = resume pending, bit 1 = system reset request, bit 0 = module active. All other bits read as 0.
- R5: While the module-active bit is 0, a control write updates only bit 0, and every other field stays 0. A control write with bit 0 = 0 clears all control fields, even if the module was active.
- R6: While the module is active, `haltReq` is a level that follows control bit 31 of the last accepted control write.
- R7: While the module is active, writing 1 to control bit 30 raises `resumeReq`. Writing 0 to bit 30 does not cancel a pending resume. `resumeReq` stays high until `coreResumeAck` is seen high at a clock edge, and drops after that edge.
- R8: A control write with bit 30 = 1, issued while a resume is already pending, is answered with BUSY and data 0. That write changes no control field.
- R9: The status register is at address 0x11 and is read-only. Bits 11 and 10 equal `coreRunning`, bits 9 and 8 equal `coreHalted`, bits 19 and 18 equal `coreHaveReset`, and bits 17 and 16 equal `coreResumeAck`. Bits 3:0 read as 2. All other bits read as 0.
- R10: The hart-information register at address 0x12 reads as 0 with SUCCESS.
- R11: A write to 0x11 or 0x12, and any read or write to another address, is answered with FAILED and data 0. Such a request changes no control field.
- R12: A successful control write is answered with SUCCESS and data 0.
- R13: While the module is active, `sysResetReq` is a level that follows control bit 1 of the last accepted control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqAddr | input | 32 | Register address |
| reqData | input | 32 | Write data |
| reqOp | input | 2 | Operation: 0 NOP, 1 READ, 2 WRITE |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Debugger takes the response |
| rspData | output | 32 | Read data, 0 for non-reads |
| rspStat | output | 2 | Status: 0 SUCCESS, 1 FAILED, 2 BUSY |
| coreHalted | input | 1 | Core is halted |
| coreRunning | input | 1 | Core is running |
| coreHaveReset | input | 1 | Core has been reset |
| coreResumeAck | input | 1 | Core acknowledges a resume |
| haltReq | output | 1 | Halt request level to the core |
| resumeReq | output | 1 | Resume request, held until acknowledged |
| sysResetReq | output | 1 | Non-debug system reset request |

## Verification
The bound assertions check the following on every cycle:
- every accepted request is followed by a response;
- a stalled response holds steady;
- status code 3 never appears;
- NOP and operation 3 get the correct answers;
- `haltReq` and `sysResetReq` rise only after an accepted write;
- `resumeReq` falls only after an acknowledge or an accepted request.

Only the bench scenarios can show the rest:
- exact register read-back values;
- the module-active gating and full clear;
- the BUSY refusal leaving the fields untouched;
- the status word mirroring each core input at its bit positions;
- failed requests leaving the control word intact.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } reqOp_e;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_FAIL = 2'd1,
    RSP_BUSY = 2'd2
  } rspCode_e;

  // control word bit positions
  localparam int CTL_HALT_BIT   = 31;
  localparam int CTL_RESUME_BIT = 30;
  localparam int CTL_RESET_BIT  = 1;
  localparam int CTL_ACTIVE_BIT = 0;

  // status word bit positions (each pair: all / any)
  localparam int ST_HAVERESET_HI = 19;
  localparam int ST_HAVERESET_LO = 18;
  localparam int ST_RESACK_HI    = 17;
  localparam int ST_RESACK_LO    = 16;
  localparam int ST_RUN_HI       = 11;
  localparam int ST_RUN_LO       = 10;
  localparam int ST_HALT_HI      = 9;
  localparam int ST_HALT_LO      = 8;
  localparam int ST_VER_W        = 4;

  typedef struct packed {
    logic accept;
    logic isRead;
    logic isWrite;
    logic isNop;
  } ctrlStrobe_t;

endpackage

// File: rtl/dbg_runctl_ctrl.sv
module dbg_runctl_ctrl
  import dbg_runctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  output logic        reqReady,
  input  logic        rspReady,
  output logic        rspValid,
  output ctrlStrobe_t strobe
);

  logic accept;

  // one transaction in flight: a waiting response blocks new requests
  assign reqReady = !rspValid;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe.accept  = accept;
    strobe.isRead  = accept && (reqOp == OP_READ);
    strobe.isWrite = accept && (reqOp == OP_WRITE);
    strobe.isNop   = accept && (reqOp == OP_NOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
    end else if (accept) begin
      rspValid <= 1'b1;
    end else if (rspReady) begin
      rspValid <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_runctl_dp.sv
module dbg_runctl_dp
  import dbg_runctl_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] CTRL_ADDR = 32'h10,
  parameter logic [31:0] STAT_ADDR = 32'h11,
  parameter logic [31:0] INFO_ADDR = 32'h12,
  parameter int          VERSION   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              coreHalted,
  input  logic              coreRunning,
  input  logic              coreHaveReset,
  input  logic              coreResumeAck,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspStat,
  output logic              haltReq,
  output logic              resumeReq,
  output logic              sysResetReq
);

  localparam logic [ADDR_W-1:0] CtrlA = CTRL_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] StatA = STAT_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] InfoA = INFO_ADDR[ADDR_W-1:0];
  localparam logic [ST_VER_W-1:0] VerVal = ST_VER_W'(VERSION);

  logic activeQ, haltQ, resetQ, resumePendQ;
  logic hitCtrl, hitStat, hitInfo;
  logic ctrlWrEn, resumeClash;
  logic [DATA_W-1:0] ctrlView, statView, nextData;
  rspCode_e nextCode;

  assign hitCtrl = (reqAddr == CtrlA);
  assign hitStat = (reqAddr == StatA);
  assign hitInfo = (reqAddr == InfoA);

  // a new resume while one is still outstanding is refused
  assign resumeClash = activeQ && resumePendQ && reqData[CTL_RESUME_BIT];

  always_comb begin
    ctrlView = '0;
    ctrlView[CTL_HALT_BIT]   = haltQ;
    ctrlView[CTL_RESUME_BIT] = resumePendQ;
    ctrlView[CTL_RESET_BIT]  = resetQ;
    ctrlView[CTL_ACTIVE_BIT] = activeQ;
  end

  // single hart: the "all" and "any" flags of each pair are the same signal
  always_comb begin
    statView = '0;
    statView[ST_HAVERESET_HI] = coreHaveReset;
    statView[ST_HAVERESET_LO] = coreHaveReset;
    statView[ST_RESACK_HI]    = coreResumeAck;
    statView[ST_RESACK_LO]    = coreResumeAck;
    statView[ST_RUN_HI]       = coreRunning;
    statView[ST_RUN_LO]       = coreRunning;
    statView[ST_HALT_HI]      = coreHalted;
    statView[ST_HALT_LO]      = coreHalted;
    statView[ST_VER_W-1:0]    = VerVal;
  end

  always_comb begin
    nextData = '0;
    nextCode = RSP_OK;
    ctrlWrEn = 1'b0;
    if (strobe.isRead) begin
      if (hitCtrl)      nextData = ctrlView;
      else if (hitStat) nextData = statView;
      else if (hitInfo) nextData = '0;
      else              nextCode = RSP_FAIL;
    end else if (strobe.isWrite) begin
      if (!hitCtrl)         nextCode = RSP_FAIL;
      else if (resumeClash) nextCode = RSP_BUSY;
      else                  ctrlWrEn = 1'b1;
    end else if (strobe.accept && !strobe.isNop) begin
      nextCode = RSP_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ     <= 1'b0;
      haltQ       <= 1'b0;
      resetQ      <= 1'b0;
      resumePendQ <= 1'b0;
    end else begin
      if (coreResumeAck) resumePendQ <= 1'b0;
      if (ctrlWrEn) begin
        if (!activeQ || !reqData[CTL_ACTIVE_BIT]) begin
          // inactive or deactivating: only the active bit lands
          activeQ     <= reqData[CTL_ACTIVE_BIT];
          haltQ       <= 1'b0;
          resetQ      <= 1'b0;
          resumePendQ <= 1'b0;
        end else begin
          haltQ  <= reqData[CTL_HALT_BIT];
          resetQ <= reqData[CTL_RESET_BIT];
          if (reqData[CTL_RESUME_BIT]) resumePendQ <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData <= '0;
      rspStat <= RSP_OK;
    end else if (strobe.accept) begin
      rspData <= nextData;
      rspStat <= nextCode;
    end
  end

  assign haltReq     = haltQ;
  assign resumeReq   = resumePendQ;
  assign sysResetReq = resetQ;

endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] CTRL_ADDR = 32'h10,
  parameter logic [31:0] STAT_ADDR = 32'h11,
  parameter logic [31:0] INFO_ADDR = 32'h12,
  parameter int          VERSION   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqOp,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspStat,
  input  logic              coreHalted,
  input  logic              coreRunning,
  input  logic              coreHaveReset,
  input  logic              coreResumeAck,
  output logic              haltReq,
  output logic              resumeReq,
  output logic              sysResetReq
);

  ctrlStrobe_t strobe;

  dbg_runctl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqReady (reqReady),
    .rspReady (rspReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  dbg_runctl_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR),
    .INFO_ADDR (INFO_ADDR),
    .VERSION   (VERSION)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqAddr       (reqAddr),
    .reqData       (reqData),
    .coreHalted    (coreHalted),
    .coreRunning   (coreRunning),
    .coreHaveReset (coreHaveReset),
    .coreResumeAck (coreResumeAck),
    .rspData       (rspData),
    .rspStat       (rspStat),
    .haltReq       (haltReq),
    .resumeReq     (resumeReq),
    .sysResetReq   (sysResetReq)
  );

endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqData,
  input logic [1:0]        reqOp,
  input logic              rspValid,
  input logic              rspReady,
  input logic [DATA_W-1:0] rspData,
  input logic [1:0]        rspStat,
  input logic              coreHalted,
  input logic              coreRunning,
  input logic              coreHaveReset,
  input logic              coreResumeAck,
  input logic              haltReq,
  input logic              resumeReq,
  input logic              sysResetReq
);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  assert_rsp_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspStat)));

  assert_no_code3_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspStat != 2'd3));

  assert_nop_ok_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 2'd0) |=> (rspStat == 2'd0 && rspData == '0));

  assert_bad_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 2'd3) |=> (rspStat == 2'd1 && rspData == '0));

  assert_halt_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(reqValid && reqReady && reqOp == 2'd2));

  assert_reset_rise_R13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetReq) |-> $past(reqValid && reqReady && reqOp == 2'd2));

  assert_resume_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resumeReq) |-> ($past(coreResumeAck) || $past(reqValid && reqReady)));

endmodule

bind dbg_runctl dbg_runctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dbg_runctl_tb.sv
`timescale 1ns/1ps
module dbg_runctl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [1:0]  reqOp = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [31:0] rspData;
  logic [1:0]  rspStat;
  logic        coreHalted = 1'b0;
  logic        coreRunning = 1'b0;
  logic        coreHaveReset = 1'b0;
  logic        coreResumeAck = 1'b0;
  logic        haltReq, resumeReq, sysResetReq;

  always #2.5 clk = ~clk;

  dbg_runctl u_dut (.*);

  typedef struct {
    logic [31:0] data;
    logic [1:0]  stat;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int holdCnt = 0;
  bit done = 1'b0;
  bit seenHold = 1'b0;
  logic [31:0] heldData;
  logic [1:0]  heldStat;

  localparam logic [1:0] OK = 2'd0, FAIL_C = 2'd1, BUSY = 2'd2;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: owns rspReady, pops the scoreboard on each handshake
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (holdCnt > 0) begin
        rspReady = 1'b0;
        if (seenHold) begin
          check(rspData == heldData, "R2 data held", rspData, heldData);
          check(rspStat == heldStat, "R2 status held", 32'(rspStat), 32'(heldStat));
        end
        check(reqReady == 1'b0, "R2 ready low while response waits", 32'(reqReady), 32'd0);
        heldData = rspData;
        heldStat = rspStat;
        seenHold = 1'b1;
        holdCnt--;
      end else begin
        rspReady = 1'b1;
        seenHold = 1'b0;
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected response", rspData, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(rspStat == e.stat, {e.tag, " status"}, 32'(rspStat), 32'(e.stat));
          check(rspData == e.data, {e.tag, " data"}, rspData, e.data);
        end
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] data,
                       input logic [31:0] expData, input logic [1:0] expStat, input string tag);
    expItem_t e;
    e.data = expData;
    e.stat = expStat;
    e.tag  = tag;
    expQ.push_back(e);
    reqOp = op;
    reqAddr = addr;
    reqData = data;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0 || rspValid) @(negedge clk);
  endtask

  task automatic outs(input bit h, input bit r, input bit s, input string tag);
    check(haltReq == h, {tag, " haltReq"}, 32'(haltReq), 32'(h));
    check(resumeReq == r, {tag, " resumeReq"}, 32'(resumeReq), 32'(r));
    check(sysResetReq == s, {tag, " sysResetReq"}, 32'(sysResetReq), 32'(s));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rspValid == 1'b0, "R1 rspValid", 32'(rspValid), 32'd0);
    check(reqReady == 1'b1, "R1 reqReady", 32'(reqReady), 32'd1);
    outs(1'b0, 1'b0, 1'b0, "R1");

    // R3 opcodes
    issue(2'd0, 32'h10, 32'hFFFF_FFFF, 32'd0, OK, "R3 nop");
    issue(2'd3, 32'h10, 32'hFFFF_FFFF, 32'd0, FAIL_C, "R3 op3");
    // R4 reset read-back
    issue(2'd1, 32'h10, 32'd0, 32'd0, OK, "R4 ctrl after reset");

    // R5 inactive: only bit 0 accepted
    issue(2'd2, 32'h10, 32'hC000_0002, 32'd0, OK, "R12 write ok");
    issue(2'd1, 32'h10, 32'd0, 32'd0, OK, "R5 inactive write ignored");
    drain();
    outs(1'b0, 1'b0, 1'b0, "R5 inactive");
    issue(2'd2, 32'h10, 32'hC000_0003, 32'd0, OK, "R5 activate");
    issue(2'd1, 32'h10, 32'd0, 32'h0000_0001, OK, "R5 only active bit lands");
    drain();
    outs(1'b0, 1'b0, 1'b0, "R5 activation write");

    // R6 / R13 levels
    issue(2'd2, 32'h10, 32'h8000_0003, 32'd0, OK, "R12 write halt+reset");
    issue(2'd1, 32'h10, 32'd0, 32'h8000_0003, OK, "R4 ctrl readback");
    drain();
    outs(1'b1, 1'b0, 1'b1, "R6 R13 set");

    // R7 resume
    issue(2'd2, 32'h10, 32'h4000_0001, 32'd0, OK, "R7 resume write");
    issue(2'd1, 32'h10, 32'd0, 32'h4000_0001, OK, "R4 resume pending read");
    drain();
    outs(1'b0, 1'b1, 1'b0, "R7 resume raised, R6 R13 cleared");

    // R8 busy refusal
    issue(2'd2, 32'h10, 32'hC000_0003, 32'd0, BUSY, "R8 busy");
    drain();
    outs(1'b0, 1'b1, 1'b0, "R8 no change");
    issue(2'd2, 32'h10, 32'h0000_0001, 32'd0, OK, "R7 zero write");
    drain();
    outs(1'b0, 1'b1, 1'b0, "R7 not cancelled");
    repeat (3) @(negedge clk);
    check(resumeReq == 1'b1, "R7 held without ack", 32'(resumeReq), 32'd1);
    coreResumeAck = 1'b1;
    @(negedge clk);
    coreResumeAck = 1'b0;
    check(resumeReq == 1'b0, "R7 cleared by ack", 32'(resumeReq), 32'd0);
    issue(2'd1, 32'h10, 32'd0, 32'h0000_0001, OK, "R7 ctrl after ack");

    // R9 status mirror
    coreHalted = 1'b1; coreRunning = 1'b0; coreHaveReset = 1'b1; coreResumeAck = 1'b0;
    issue(2'd1, 32'h11, 32'd0, 32'h000C_0302, OK, "R9 status halted");
    coreHalted = 1'b0; coreRunning = 1'b1; coreHaveReset = 1'b0; coreResumeAck = 1'b1;
    issue(2'd1, 32'h11, 32'd0, 32'h0003_0C02, OK, "R9 status running");
    coreResumeAck = 1'b0;
    issue(2'd1, 32'h11, 32'd0, 32'h0000_0C02, OK, "R9 status version");

    // R10 / R11
    issue(2'd1, 32'h12, 32'd0, 32'd0, OK, "R10 hartinfo");
    issue(2'd2, 32'h11, 32'hFFFF_FFFF, 32'd0, FAIL_C, "R11 write status");
    issue(2'd2, 32'h12, 32'hFFFF_FFFF, 32'd0, FAIL_C, "R11 write hartinfo");
    issue(2'd1, 32'h20, 32'd0, 32'd0, FAIL_C, "R11 read unmapped");
    issue(2'd2, 32'h110, 32'hC000_0003, 32'd0, FAIL_C, "R11 write unmapped");
    issue(2'd1, 32'h10, 32'd0, 32'h0000_0001, OK, "R11 ctrl untouched");
    drain();
    outs(1'b0, 1'b0, 1'b0, "R11 outputs untouched");

    // R2 back-pressure
    issue(2'd2, 32'h10, 32'h8000_0003, 32'd0, OK, "R12 write before stall");
    drain();
    holdCnt = 4;
    issue(2'd1, 32'h10, 32'd0, 32'h8000_0003, OK, "R2 stalled read");
    issue(2'd0, 32'h0, 32'd0, 32'd0, OK, "R2 after stall");

    // R5 deactivate clears everything
    issue(2'd2, 32'h10, 32'hC000_0002, 32'd0, OK, "R5 deactivate");
    drain();
    outs(1'b0, 1'b0, 1'b0, "R5 deactivated");
    issue(2'd1, 32'h10, 32'd0, 32'd0, OK, "R5 ctrl cleared");
    drain();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule